// File: doc/BRIEF.md
# Telemetry Frame Sequencer

The sequencer orders the events of every downlink transfer frame. A frame is three phases in a fixed order. First the sync marker is shifted out. Next the message bits pass through the encoder. Last, if encoding is enabled, the check bytes are shifted out. Each bit of every phase takes one downlink bit-rate tick. The block emits one strobe per tick to whichever downstream block owns the current phase, so the sync generator and the encoder only shift on its command.

Frames are grouped into two downlink buffers used alternately. After a fixed number of frames the active buffer flips. At the start of the first frame of each buffer, the block latches the spacecraft time presented on its time input, so software can tie a time value to that frame's first bit.

Software can arm a resynchronisation. Once armed, the sequencer finishes the current frame and then holds off until a real-time interrupt pulse. It then starts a frame at once in the buffer software selected, and the buffer frame count begins again from zero. Sticky interrupt flags record buffer swaps, time captures and completed resyncs.

Top module: `frame_sequencer`

## Requirements
- R1: Reset state. After reset all strobes are low, `seq_state` is 0 (idle), `active_buf`, `stamp`, `irq_flags` and `irq` are 0, and `enc_on` and `arm_pending` are 0.
- R2: Zero length. While the frame-length register (address 0, low LEN_W bits) holds 0, the sequencer stays idle and emits no strobe, even while ticks arrive.
- R3: Phase order and length. A frame gives SYNC_BITS sync strobes, then exactly L message strobes, then 256*INTERLEAVE check strobes. L is the frame length. Frames follow back to back and at most one strobe is high at a time. The `seq_state` codes are: 0 idle, 1 waiting for interrupt, 2 sync, 3 message, 4 check.
- R4: Encoder off. When control bit 0 (address 1) is 0 at frame start, the check phase is skipped and the next frame's sync phase follows the last message bit directly.
- R5: Tick pacing. A strobe occurs only in a cycle with `bit_tick` high. Cycles without a tick neither advance the phase nor shorten it.
- R6: Frame-start latching. The frame length and the encoder enable are captured when a frame enters its sync phase. Writes made during a frame take effect from the next frame.
- R7: Buffer swap. After BUF_FRAMES frames in a buffer, `active_buf` flips at the frame boundary and flag bit 0 is set.
- R8: Time capture. When the first frame of a buffer enters its sync phase, `stamp` takes the `sc_time` value sampled on that clock edge and flag bit 1 is set. The stamp is unchanged for the other frames.
- R9: Resync. Writing 1 to control bit 1 arms a resync. Control bit 2 gives the target buffer. The current frame completes and the sequencer then waits (state 1) with no strobes. On an `rti` pulse it enters sync on the next edge, with `active_buf` set to the target and the buffer frame count at zero. It then clears the arm and sets flag bit 2.
- R10: Flags. The flags at address 2 are sticky. Writing 1 to a bit clears it and writing 0 has no effect. If a set and a clear meet in one cycle, the set wins. `irq` is the OR of the three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 length, 1 control, 2 flags |
| wr_data | input | 32 | Register write data |
| bit_tick | input | 1 | Downlink bit-rate tick |
| rti | input | 1 | Real-time interrupt pulse |
| sc_time | input | TIME_W | Spacecraft time |
| sync_shift | output | 1 | Shift one sync-marker bit |
| msg_shift | output | 1 | Pass one message bit through the encoder |
| chk_shift | output | 1 | Shift one check bit out |
| seq_state | output | 3 | Sequencer state code |
| active_buf | output | 1 | Current downlink buffer |
| stamp | output | TIME_W | Time latched at the first frame of a buffer |
| irq_flags | output | 3 | Sticky flags: bit0 swap, bit1 time, bit2 resync |
| irq | output | 1 | OR of the flags |
| frame_len | output | LEN_W | Frame-length register |
| enc_on | output | 1 | Encoder-enable register |
| arm_pending | output | 1 | Resync armed and not yet taken |

## Verification
A wrong phase counter shows in the first frame as a sync, message or check run that is too long or too short. The bench counts strobes tick by tick, so the error is visible within one frame. A wrong buffer frame count shows as a flip of `active_buf` one frame early or late, and as a timestamp taken on the wrong frame. A resync that does not clear the count shows one frame after the interrupt. Because flag and latch errors persist, the bench compares them at every frame boundary and after each register write.

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int LEN_W      = 16,
  parameter int TIME_W     = 32,
  parameter int SYNC_BITS  = 32,
  parameter int INTERLEAVE = 5,
  parameter int BUF_FRAMES = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              bit_tick,
  input  logic              rti,
  input  logic [TIME_W-1:0] sc_time,
  output logic              sync_shift,
  output logic              msg_shift,
  output logic              chk_shift,
  output logic [2:0]        seq_state,
  output logic              active_buf,
  output logic [TIME_W-1:0] stamp,
  output logic [2:0]        irq_flags,
  output logic              irq,
  output logic [LEN_W-1:0]  frame_len,
  output logic              enc_on,
  output logic              arm_pending
);
  localparam int CHK_BITS = 256 * INTERLEAVE;
  localparam int CW_A  = $clog2(CHK_BITS) > $clog2(SYNC_BITS) ? $clog2(CHK_BITS) : $clog2(SYNC_BITS);
  localparam int CNT_W = LEN_W > CW_A ? LEN_W : CW_A;
  localparam int FR_W  = BUF_FRAMES > 1 ? $clog2(BUF_FRAMES) : 1;

  typedef enum logic [2:0] {IDLE = 3'd0, WAIT = 3'd1, SYNC = 3'd2, MSG = 3'd3, CHK = 3'd4} st_t;

  st_t              st, st_n, after_frame;
  logic [CNT_W-1:0] cnt;
  logic [FR_W-1:0]  frm, frm_n;
  logic [LEN_W-1:0] len_r, cur_len;
  logic             enc_r, cur_enc, arm_r, sel_r, buf_r;
  logic [2:0]       flags_r, flag_set, flag_clr;
  logic [TIME_W-1:0] stamp_r;

  wire go        = len_r != '0;
  wire last_sync = cnt == CNT_W'(SYNC_BITS - 1);
  wire last_msg  = cnt == CNT_W'(cur_len) - CNT_W'(1);
  wire last_chk  = cnt == CNT_W'(CHK_BITS - 1);
  wire frame_end = bit_tick & (((st == MSG) & last_msg & ~cur_enc) | ((st == CHK) & last_chk));
  wire buf_end   = frame_end & (frm == FR_W'(BUF_FRAMES - 1));
  wire rti_go    = (st == WAIT) & (st_n == SYNC);
  wire enter     = (st_n == SYNC) & (st != SYNC);
  wire capture   = enter & (frm_n == '0);
  wire ctrl_wr   = wr_en & (wr_addr == 2'd1);

  assign after_frame = !go ? IDLE : (arm_r ? WAIT : SYNC);

  always_comb begin
    st_n = st;
    case (st)
      IDLE: if (go) st_n = arm_r ? WAIT : SYNC;
      WAIT: if (rti & go) st_n = SYNC;
      SYNC: if (bit_tick & last_sync) st_n = MSG;
      MSG:  if (bit_tick & last_msg) st_n = cur_enc ? CHK : after_frame;
      CHK:  if (bit_tick & last_chk) st_n = after_frame;
      default: st_n = IDLE;
    endcase
  end

  always_comb begin
    frm_n = frm;
    if (rti_go || buf_end) frm_n = '0;
    else if (frame_end)    frm_n = frm + FR_W'(1);
  end

  assign flag_set = {rti_go, capture, buf_end};
  assign flag_clr = (wr_en && wr_addr == 2'd2) ? wr_data[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; frm <= '0;
      len_r <= '0; enc_r <= 1'b0; arm_r <= 1'b0; sel_r <= 1'b0;
      cur_len <= '0; cur_enc <= 1'b0; buf_r <= 1'b0;
      flags_r <= '0; stamp_r <= '0;
    end else begin
      st  <= st_n;
      frm <= frm_n;
      if (st_n != st) cnt <= '0;
      else if (bit_tick && (st == SYNC || st == MSG || st == CHK)) cnt <= cnt + CNT_W'(1);
      if (wr_en && wr_addr == 2'd0) len_r <= wr_data[LEN_W-1:0];
      if (ctrl_wr) begin
        enc_r <= wr_data[0];
        sel_r <= wr_data[2];
      end
      arm_r <= (ctrl_wr & wr_data[1]) | (arm_r & ~rti_go);
      if (enter) begin
        cur_len <= len_r;
        cur_enc <= enc_r;
      end
      if (rti_go)       buf_r <= sel_r;
      else if (buf_end) buf_r <= ~buf_r;
      if (capture) stamp_r <= sc_time;
      flags_r <= (flags_r & ~flag_clr) | flag_set;
    end
  end

  assign sync_shift  = (st == SYNC) & bit_tick;
  assign msg_shift   = (st == MSG)  & bit_tick;
  assign chk_shift   = (st == CHK)  & bit_tick;
  assign seq_state   = st;
  assign active_buf  = buf_r;
  assign stamp       = stamp_r;
  assign irq_flags   = flags_r;
  assign irq         = |flags_r;
  assign frame_len   = len_r;
  assign enc_on      = enc_r;
  assign arm_pending = arm_r;

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_shift, msg_shift, chk_shift}));
  a_r3_msg_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MSG && $past(st) != MSG) |-> $past(st) == SYNC);
  a_r4_chk_needs_enc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CHK) |-> cur_enc);
  a_r2_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && len_r == '0) |=> st == IDLE);
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && (st == SYNC || st == MSG || st == CHK)) |=> (st == $past(st) && cnt == $past(cnt)));
  a_r7_swap: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end |=> (active_buf != $past(active_buf) && irq_flags[0]));
  a_r8_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SYNC && $past(st) != SYNC && frm == '0) |-> stamp == $past(sc_time));
  a_r9_resync_target: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT && rti && go) |=> (st == SYNC && active_buf == $past(sel_r) && irq_flags[2]));
endmodule

// File: tb/tb_frame_sequencer.sv
module tb_frame_sequencer;
  localparam int LEN_W = 8, TIME_W = 16, SYNC_N = 32, ILV = 1, BUFN = 2;
  localparam int CHKN = 256 * ILV;

  logic clk = 0, rst_n = 0, wr_en = 0, bit_tick = 0, rti = 0;
  logic [1:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [TIME_W-1:0] sc_time = 0;
  logic sync_shift, msg_shift, chk_shift, active_buf, irq, enc_on, arm_pending;
  logic [2:0] seq_state, irq_flags;
  logic [TIME_W-1:0] stamp;
  logic [LEN_W-1:0] frame_len;

  int checks = 0, errors = 0;
  logic [TIME_W-1:0] last_start = 0;
  logic [TIME_W-1:0] t1;

  frame_sequencer #(.LEN_W(LEN_W), .TIME_W(TIME_W), .SYNC_BITS(SYNC_N),
                    .INTERLEAVE(ILV), .BUF_FRAMES(BUFN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_tick(bit_tick), .rti(rti), .sc_time(sc_time),
    .sync_shift(sync_shift), .msg_shift(msg_shift), .chk_shift(chk_shift),
    .seq_state(seq_state), .active_buf(active_buf), .stamp(stamp),
    .irq_flags(irq_flags), .irq(irq), .frame_len(frame_len),
    .enc_on(enc_on), .arm_pending(arm_pending));

  always #10 clk = ~clk;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit t, bit we = 0, logic [1:0] a = 0, logic [31:0] d = 0, bit r = 0);
    @(negedge clk);
    bit_tick = t; wr_en = we; wr_addr = a; wr_data = d; rti = r;
    #1;
    sc_time = sc_time + 1'b1;
    sc_time = sc_time - 1'b1;
  endtask

  // advance time after sampling: called at the end of each loop iteration
  task automatic tick_time();
    sc_time = sc_time + 1'b1;
  endtask

  task automatic frame(int len, bit enc, int per, string req,
                       int wat = -1, logic [1:0] wa = 0, logic [31:0] wd = 0);
    int total = SYNC_N + len + (enc ? CHKN : 0);
    int i = 0, c = 0, w = 0, bad = 0;
    bit started = 0;
    while (i < total && w < 8) begin
      bit t = (c % per) == 0;
      bit we = started && (i == wat) && t;
      logic [2:0] exp;
      step(t, we, wa, wd);
      c++;
      if (!started) begin
        if (seq_state == 3'd2) begin
          started = 1;
          last_start = sc_time;
        end else begin
          w++;
          tick_time();
          continue;
        end
      end
      if (t) begin
        exp = (i < SYNC_N) ? 3'b100 : (i < SYNC_N + len) ? 3'b010 : 3'b001;
        if ({sync_shift, msg_shift, chk_shift} != exp) bad++;
        i++;
      end else if ({sync_shift, msg_shift, chk_shift} != 3'b000) bad++;
      tick_time();
    end
    check(started && bad == 0, req, "frame strobe mismatches", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(1); tick_time();
    // R1 reset state
    check({sync_shift, msg_shift, chk_shift} == 0 && seq_state == 0, "R1", "strobes/state", seq_state, 0);
    check(active_buf == 0 && stamp == 0 && irq_flags == 0 && irq == 0, "R1", "buf/stamp/flags", irq_flags, 0);
    check(enc_on == 0 && arm_pending == 0 && frame_len == 0, "R1", "registers", frame_len, 0);

    // R2 zero length: no strobes while ticks arrive
    step(1, 1, 2'd1, 32'd1); tick_time();
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        step(1); tick_time();
        if (sync_shift || msg_shift || chk_shift || seq_state != 0) seen++;
      end
      check(seen == 0, "R2", "activity with zero length", seen, 0);
    end
    check(enc_on == 1, "R2", "encoder enable readback", enc_on, 1);

    // R3 first frames with encoder on; R8 stamp on the first frame of a buffer
    step(1, 1, 2'd0, 32'd8); tick_time();
    frame(8, 1, 1, "R3");
    t1 = last_start;
    check(stamp == t1, "R8", "stamp on first frame", stamp, t1);
    check(irq_flags[1] == 1 && irq_flags[0] == 0, "R8", "time flag only", irq_flags, 2);
    frame(8, 1, 1, "R3");
    check(stamp == t1, "R8", "stamp held on second frame", stamp, t1);
    check(active_buf == 0, "R7", "buffer before boundary", active_buf, 0);
    frame(8, 1, 1, "R7");
    check(active_buf == 1, "R7", "buffer after boundary", active_buf, 1);
    check(irq_flags[0] == 1, "R7", "swap flag", irq_flags, 1);
    check(stamp == last_start, "R8", "stamp on new buffer", stamp, last_start);

    // R6 encoder disable written mid-frame applies next frame; R4 check skipped
    frame(8, 1, 1, "R6", 40, 2'd1, 32'd0);
    frame(8, 0, 1, "R4");
    check(active_buf == 0, "R7", "buffer swapped back", active_buf, 0);
    // R6 length written mid-frame
    frame(8, 0, 1, "R6", 10, 2'd0, 32'd3);
    frame(3, 0, 3, "R5");
    frame(3, 0, 2, "R5");
    // first frame of buffer 0 again; drop length to 0 during it
    frame(3, 0, 1, "R6", 1, 2'd0, 32'd0);
    check(active_buf == 0 && stamp == last_start, "R8", "stamp after second swap", stamp, last_start);
    step(1); tick_time(); step(1); tick_time();
    check(seq_state == 0 && !sync_shift, "R2", "idle after length cleared", seq_state, 0);

    // R10 flags
    check(irq_flags == 3'b011 && irq == 1, "R10", "flags before clear", irq_flags, 3);
    step(1, 1, 2'd2, 32'd0); tick_time(); step(1); tick_time();
    check(irq_flags == 3'b011, "R10", "write zero no effect", irq_flags, 3);
    step(1, 1, 2'd2, 32'd1); tick_time(); step(1); tick_time();
    check(irq_flags == 3'b010 && irq == 1, "R10", "clear bit0", irq_flags, 2);
    step(1, 1, 2'd2, 32'd2); tick_time(); step(1); tick_time();
    check(irq_flags == 3'b000 && irq == 0, "R10", "clear bit1", irq_flags, 0);

    // R9 resync to buffer 1
    step(1, 1, 2'd1, 32'd6); tick_time();
    step(1, 1, 2'd0, 32'd5); tick_time();
    begin
      int seen = 0, wst = 0;
      for (int k = 0; k < 20; k++) begin
        step(1); tick_time();
        if (sync_shift || msg_shift || chk_shift) seen++;
        if (seq_state != 3'd1) wst++;
      end
      check(seen == 0 && wst <= 1, "R9", "waiting quietly", seen, 0);
    end
    check(arm_pending == 1, "R9", "arm pending", arm_pending, 1);
    step(1, 0, 0, 0, 1); tick_time();
    frame(5, 0, 1, "R9");
    check(active_buf == 1, "R9", "target buffer", active_buf, 1);
    check(irq_flags == 3'b110 && arm_pending == 0, "R9", "resync and time flags", irq_flags, 6);
    check(stamp == last_start, "R9", "stamp at resync frame", stamp, last_start);
    frame(5, 0, 1, "R9");
    check(active_buf == 1, "R9", "frame count restarted", active_buf, 1);
    frame(5, 0, 1, "R9");
    check(active_buf == 0 && irq_flags[0] == 1, "R9", "swap after resync buffer", active_buf, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule